// File: doc/BRIEF.md
# Receive Robbed-Bit Signaling Capture

This block recovers the robbed-bit signaling of the 24 voice channels in a received T1 stream. A framer upstream delivers the stream one channel byte per strobe, tagged with the frame number inside the multiframe and the channel index. It also marks each multiframe boundary with a one-cycle strobe. The signaling bit of a channel is the least significant bit of its byte in the signaling frames. Those bits collect in a shadow store while the multiframe runs. At the boundary they move into twelve host-visible 8-bit registers in a single clock edge, so the host never reads a mix of two multiframes.

The framing mode is selected by an input. With extended superframe framing, each channel carries four bits (A, B, C, D). With 12-frame superframe framing, each channel carries only A and B. In that mode the C and D registers are loaded with the A and B values that were visible before the update. A host that polls at the extended-superframe rate therefore never misses a change in either mode. When a boundary updates the registers, a sticky event flag rises and stays up until the host clears it by writing one. While the framer reports loss of sync, boundaries are ignored. The registers keep the last values captured before sync was lost.

Top module: `rx_sig_capture`

## Requirements
- R1: After reset, all twelve signaling registers read 0x00 and the multiframe event flag is low.
- R2: Register address = 3*s + (n-1)/8 and bit = (n-1) mod 8, where n is the channel number 1..24 and s is 0 for A, 1 for B, 2 for C and 3 for D. `host_rdata` follows `host_addr` in the same cycle. Addresses 12 to 15 read 0x00.
- R3: In extended superframe mode (`mode_esf`=1), bit 0 of the channel byte is captured as A in frame 6, B in frame 12, C in frame 18 and D in frame 24. The other bits and the other frames are ignored.
- R4: In superframe mode (`mode_esf`=0), only frame 6 (A) and frame 12 (B) are captured. Bytes tagged frame 18 or 24 have no effect on any register.
- R5: In superframe mode, each update loads the C registers with the A values and the D registers with the B values that were visible just before that update.
- R6: Register contents change only on the clock edge that samples `mf_boundary` high. Bytes arriving during a multiframe are not visible before the next boundary.
- R7: A boundary that updates the registers sets `mf_event`, visible one cycle after the strobe.
- R8: A one-cycle `evt_clr` pulse clears `mf_event`. If `evt_clr` and an updating boundary occur in the same cycle, the flag ends up set.
- R9: While `sync_lost`=1, a boundary changes no register and does not set `mf_event`. The next boundary after sync returns updates normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_valid | input | 1 | Channel byte strobe |
| ch_data | input | 8 | Received channel byte |
| frame_num | input | 5 | Frame number in multiframe, 1..24 |
| ch_idx | input | 5 | Channel index, 0..23 for channels 1..24 |
| mf_boundary | input | 1 | One-cycle multiframe boundary strobe |
| mode_esf | input | 1 | 1 = extended superframe, 0 = 12-frame superframe |
| sync_lost | input | 1 | Loss of frame synchronization |
| evt_clr | input | 1 | Write-one-to-clear strobe for the event flag |
| host_addr | input | 4 | Register address |
| host_rdata | output | 8 | Register read data |
| mf_event | output | 1 | Sticky multiframe update flag |

## Verification
A wrong shadow bit stays hidden until the next boundary. At that point it shows up at one bit position of one register, and it is visible one cycle after the strobe. A bad superframe substitution shows in the C or D registers at the same point, because those registers must equal the A and B values read one multiframe earlier. A freeze that leaks, or a flag that is set or cleared at the wrong time, shows at the ports in the cycle after the offending boundary or clear pulse.

// File: rtl/rsig_pkg.sv
// Package: shared constants for the robbed-bit signaling capture.
// Assumes frames are numbered 1..24 and the signaling bit is bit 0.
package rsig_pkg;
    localparam int SIG_KINDS = 4;        // A, B, C, D
    localparam int FRAME_W   = 5;
    localparam int FR_SIG_A  = 6;
    localparam int FR_SIG_B  = 12;
    localparam int FR_SIG_C  = 18;
    localparam int FR_SIG_D  = 24;

    typedef enum logic [1:0] {
        SIG_A = 2'd0,
        SIG_B = 2'd1,
        SIG_C = 2'd2,
        SIG_D = 2'd3
    } sig_kind_e;
endpackage

// File: rtl/rsig_extract.sv
// Module: rsig_extract
// Collects the robbed bit of each channel into a shadow store, one slice
// per signaling kind. Assumes ch_idx < N_CH when ch_valid is high.
// In superframe mode the C and D slices are never written.
module rsig_extract
    import rsig_pkg::*;
#(
    parameter int N_CH = 24,
    parameter int CH_W = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ch_valid,
    input  logic [7:0]                        ch_data,
    input  logic [FRAME_W-1:0]                frame_num,
    input  logic [CH_W-1:0]                   ch_idx,
    input  logic                              mode_esf,
    output logic [SIG_KINDS-1:0][N_CH-1:0]    shadow_q
);
    logic hit_a, hit_b, hit_c, hit_d;
    logic unused_hi;

    assign unused_hi = ^ch_data[7:1];

    // Decode which signaling kind the current byte carries.
    always_comb begin
        hit_a = ch_valid && (frame_num == FRAME_W'(FR_SIG_A));
        hit_b = ch_valid && (frame_num == FRAME_W'(FR_SIG_B));
        hit_c = ch_valid && mode_esf && (frame_num == FRAME_W'(FR_SIG_C));
        hit_d = ch_valid && mode_esf && (frame_num == FRAME_W'(FR_SIG_D));
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        logic sel;
        assign sel = (ch_idx == CH_W'(ch));

        // Store the LSB of this channel's byte in the slice of its kind.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q[SIG_A][ch] <= 1'b0;
                shadow_q[SIG_B][ch] <= 1'b0;
                shadow_q[SIG_C][ch] <= 1'b0;
                shadow_q[SIG_D][ch] <= 1'b0;
            end else if (sel) begin
                if (hit_a) shadow_q[SIG_A][ch] <= ch_data[0];
                if (hit_b) shadow_q[SIG_B][ch] <= ch_data[0];
                if (hit_c) shadow_q[SIG_C][ch] <= ch_data[0];
                if (hit_d) shadow_q[SIG_D][ch] <= ch_data[0];
            end
        end
    end

    // R3
    // shadow_stable_chk: with no byte strobe the shadow store holds.
    shadow_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_valid |=> $stable(shadow_q));

    // R4
    // d4_cd_untouched_chk: superframe bytes never write the C/D slices.
    d4_cd_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid && !mode_esf) |=> ($stable(shadow_q[SIG_C]) && $stable(shadow_q[SIG_D])));
endmodule

// File: rtl/rsig_bank.sv
// Module: rsig_bank
// Visible signaling registers and the sticky event flag. Copies the shadow
// store on an accepted boundary; in superframe mode C/D take the prior A/B.
// Assumes mf_boundary is a single-cycle pulse not coinciding with ch_valid.
module rsig_bank
    import rsig_pkg::*;
#(
    parameter int N_CH = 24
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              mf_boundary,
    input  logic                              sync_lost,
    input  logic                              mode_esf,
    input  logic                              evt_clr,
    input  logic [SIG_KINDS-1:0][N_CH-1:0]    shadow_q,
    output logic [SIG_KINDS-1:0][N_CH-1:0]    vis_q,
    output logic                              evt_q
);
    logic upd;

    assign upd = mf_boundary && !sync_lost;

    // Transfer all signaling at once on an accepted boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis_q <= '0;
        end else if (upd) begin
            vis_q[SIG_A] <= shadow_q[SIG_A];
            vis_q[SIG_B] <= shadow_q[SIG_B];
            if (mode_esf) begin
                vis_q[SIG_C] <= shadow_q[SIG_C];
                vis_q[SIG_D] <= shadow_q[SIG_D];
            end else begin
                vis_q[SIG_C] <= vis_q[SIG_A];
                vis_q[SIG_D] <= vis_q[SIG_B];
            end
        end
    end

    // Sticky event flag: set on update, cleared by write-one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       evt_q <= 1'b0;
        else if (upd)     evt_q <= 1'b1;
        else if (evt_clr) evt_q <= 1'b0;
    end

    // R6
    // vis_hold_chk: without an accepted boundary the registers hold.
    vis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mf_boundary && !sync_lost) |=> $stable(vis_q));

    // R5
    // d4_shift_chk: superframe update moves the old A/B into C/D.
    d4_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !mode_esf) |=> (vis_q[SIG_C] == $past(vis_q[SIG_A]) &&
                                vis_q[SIG_D] == $past(vis_q[SIG_B])));

    // R3
    // esf_copy_chk: extended-superframe update copies all four slices.
    esf_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && mode_esf) |=> (vis_q == $past(shadow_q)));

    // R7
    // evt_set_chk: an accepted boundary raises the event flag.
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> evt_q);

    // R8
    // evt_clr_chk: a clear without a boundary drops the flag.
    evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr && !upd) |=> !evt_q);

    // R9
    // freeze_evt_chk: during loss of sync the flag never rises.
    freeze_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_lost && !evt_q) |=> !evt_q);
endmodule

// File: rtl/rsig_hostport.sv
// Module: rsig_hostport
// Maps the visible signaling bits onto byte registers and serves reads.
// Register r = kind*BANKS + bank holds channels bank*8 .. bank*8+7, LSB first.
module rsig_hostport
    import rsig_pkg::*;
#(
    parameter int N_CH       = 24,
    parameter int CH_PER_REG = 8,
    parameter int ADDR_W     = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [SIG_KINDS-1:0][N_CH-1:0]    vis_q,
    input  logic [ADDR_W-1:0]                 host_addr,
    output logic [CH_PER_REG-1:0]             host_rdata
);
    localparam int BANKS = N_CH / CH_PER_REG;
    localparam int NREG  = SIG_KINDS * BANKS;

    logic [CH_PER_REG-1:0] regs [NREG];

    for (genvar k = 0; k < SIG_KINDS; k++) begin : g_kind
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            assign regs[k*BANKS + b] = vis_q[k][b*CH_PER_REG +: CH_PER_REG];
        end
    end

    // Combinational read mux; out-of-range addresses read zero.
    always_comb begin
        host_rdata = '0;
        for (int r = 0; r < NREG; r++) begin
            if (host_addr == ADDR_W'(r)) host_rdata = regs[r];
        end
    end

    // R2
    // unmapped_zero_chk: addresses past the last register read zero.
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(host_addr) >= NREG) |-> (host_rdata == '0));
endmodule

// File: rtl/rx_sig_capture.sv
// Module: rx_sig_capture (top)
// Receive robbed-bit signaling capture for a T1 stream. Assumes an upstream
// framer supplies frame number, channel index, boundary strobe and sync state.
module rx_sig_capture
    import rsig_pkg::*;
#(
    parameter int N_CH       = 24,
    parameter int CH_PER_REG = 8,
    parameter int CH_W       = 5,
    parameter int ADDR_W     = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ch_valid,
    input  logic [7:0]              ch_data,
    input  logic [FRAME_W-1:0]      frame_num,
    input  logic [CH_W-1:0]         ch_idx,
    input  logic                    mf_boundary,
    input  logic                    mode_esf,
    input  logic                    sync_lost,
    input  logic                    evt_clr,
    input  logic [ADDR_W-1:0]       host_addr,
    output logic [CH_PER_REG-1:0]   host_rdata,
    output logic                    mf_event
);
    logic [SIG_KINDS-1:0][N_CH-1:0] shadow_q;
    logic [SIG_KINDS-1:0][N_CH-1:0] vis_q;

    rsig_extract #(.N_CH(N_CH), .CH_W(CH_W)) u_extract (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_valid  (ch_valid),
        .ch_data   (ch_data),
        .frame_num (frame_num),
        .ch_idx    (ch_idx),
        .mode_esf  (mode_esf),
        .shadow_q  (shadow_q)
    );

    rsig_bank #(.N_CH(N_CH)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .mf_boundary (mf_boundary),
        .sync_lost   (sync_lost),
        .mode_esf    (mode_esf),
        .evt_clr     (evt_clr),
        .shadow_q    (shadow_q),
        .vis_q       (vis_q),
        .evt_q       (mf_event)
    );

    rsig_hostport #(.N_CH(N_CH), .CH_PER_REG(CH_PER_REG), .ADDR_W(ADDR_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .vis_q      (vis_q),
        .host_addr  (host_addr),
        .host_rdata (host_rdata)
    );
endmodule

// File: tb/tb_rx_sig_capture.sv
// Directed bench for rx_sig_capture; keeps its own model of the registers.
module tb_rx_sig_capture;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ch_valid, mf_boundary, mode_esf, sync_lost, evt_clr;
    logic [7:0] ch_data;
    logic [4:0] frame_num, ch_idx;
    logic [3:0] host_addr;
    logic [7:0] host_rdata;
    logic       mf_event;

    int checks = 0;
    int fails  = 0;

    logic [23:0] e_vis [4];
    logic [23:0] e_sh  [4];
    logic        e_evt;

    always #4 clk = ~clk;

    rx_sig_capture dut (
        .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_data(ch_data),
        .frame_num(frame_num), .ch_idx(ch_idx), .mf_boundary(mf_boundary),
        .mode_esf(mode_esf), .sync_lost(sync_lost), .evt_clr(evt_clr),
        .host_addr(host_addr), .host_rdata(host_rdata), .mf_event(mf_event)
    );

    function automatic logic [7:0] gen_byte(int seed, int f, int c);
        int p;
        p = (seed + 1) * (c + 3) * (f + 7) + seed * c;
        return p[9:2];
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Drive frames f0..f1 for all channels and update the model shadow.
    task automatic send_frames(int seed, int f0, int f1);
        for (int f = f0; f <= f1; f++) begin
            for (int c = 0; c < 24; c++) begin
                logic [7:0] d;
                d = gen_byte(seed, f, c);
                @(negedge clk);
                ch_valid = 1'b1; ch_data = d;
                frame_num = 5'(f); ch_idx = 5'(c);
                if (f == 6)              e_sh[0][c] = d[0];
                if (f == 12)             e_sh[1][c] = d[0];
                if (mode_esf && f == 18) e_sh[2][c] = d[0];
                if (mode_esf && f == 24) e_sh[3][c] = d[0];
            end
        end
        @(negedge clk);
        ch_valid = 1'b0;
    endtask

    // One boundary strobe, optionally with a simultaneous clear.
    task automatic boundary(logic clr);
        @(negedge clk);
        mf_boundary = 1'b1; evt_clr = clr;
        if (!sync_lost) begin
            if (mode_esf) begin
                e_vis[2] = e_sh[2]; e_vis[3] = e_sh[3];
            end else begin
                e_vis[2] = e_vis[0]; e_vis[3] = e_vis[1];
            end
            e_vis[0] = e_sh[0]; e_vis[1] = e_sh[1];
            e_evt = 1'b1;
        end else if (clr) begin
            e_evt = 1'b0;
        end
        @(negedge clk);
        mf_boundary = 1'b0; evt_clr = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); evt_clr = 1'b1;
        @(negedge clk); evt_clr = 1'b0;
        e_evt = 1'b0;
    endtask

    task automatic check_regs(string req);
        for (int r = 0; r < 16; r++) begin
            logic [7:0] exp;
            host_addr = 4'(r);
            #1;
            exp = (r < 12) ? e_vis[r / 3][(r % 3) * 8 +: 8] : 8'h00;
            chk(req, host_rdata, exp);
        end
    endtask

    task automatic check_evt(string req);
        chk(req, {7'd0, mf_event}, {7'd0, e_evt});
    endtask

    task automatic t_reset();
        check_regs("R1 reset value / R2 unmapped");
        check_evt("R1 event flag after reset");
    endtask

    task automatic t_esf_capture();
        mode_esf = 1'b1;
        send_frames(1, 1, 24);
        boundary(1'b0);
        check_regs("R3 ESF capture, R2 layout");
        check_evt("R7 flag after boundary");
    endtask

    task automatic t_hold_mid();
        send_frames(2, 1, 13);
        check_regs("R6 no change mid-multiframe");
        send_frames(2, 14, 24);
        check_regs("R6 no change before boundary");
        boundary(1'b0);
        check_regs("R2 R3 second ESF multiframe");
    endtask

    task automatic t_clear();
        do_clear();
        check_evt("R8 write-one clear");
        boundary(1'b1);
        check_evt("R8 set wins over clear");
        do_clear();
        check_evt("R8 clear again");
    endtask

    task automatic t_d4();
        mode_esf = 1'b0;
        send_frames(3, 1, 24);
        boundary(1'b0);
        check_regs("R4 R5 first D4 multiframe");
        send_frames(4, 1, 24);
        boundary(1'b0);
        check_regs("R5 D4 C/D hold previous A/B");
        check_evt("R7 flag in D4");
    endtask

    task automatic t_sync_loss();
        mode_esf = 1'b1;
        do_clear();
        @(negedge clk); sync_lost = 1'b1;
        send_frames(5, 1, 24);
        boundary(1'b0);
        check_regs("R9 frozen during loss of sync");
        check_evt("R9 no flag during loss of sync");
        @(negedge clk); sync_lost = 1'b0;
        boundary(1'b0);
        check_regs("R9 update resumes after sync");
        check_evt("R9 flag after sync returns");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ch_valid = 1'b0; ch_data = '0; frame_num = '0; ch_idx = '0;
        mf_boundary = 1'b0; mode_esf = 1'b1; sync_lost = 1'b0; evt_clr = 1'b0;
        host_addr = '0;
        for (int k = 0; k < 4; k++) begin
            e_vis[k] = '0; e_sh[k] = '0;
        end
        e_evt = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_esf_capture();
        t_hold_mid();
        t_clear();
        t_d4();
        t_sync_loss();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule